// File: doc/BRIEF.md
# Fan-out Enable Serial Slave

This block is the control side of a clock fan-out buffer. It is a two-wire serial slave at the fixed 7-bit address 1101001. It oversamples the SCL and SDA lines with a faster system clock and keeps a small register bank. That bank drives one enable for each of six output pairs and one enable for the feedback output. The master can write the bank in block transfers and read it back, and one bit in the bank reports the level of the DDR/SDR mode-select pin.

Every transfer is sequential and has no register addressing. In a write, the slave acknowledges the first two bytes after the address (a command byte and a count byte) and then discards them. The bytes that follow fill the bank from data byte 0 upward. In a read, the slave first returns a count byte of 9 and then sends the data bytes in ascending order. A START, including a repeated START, restarts the byte sequence from the beginning.

The slave pulls SDA low by asserting `sda_oe_o`, and the bus is open-drain. The block never stretches the clock.

Top module: `fanout_enable_slave`

## Requirements
- R1: After reset, all six `pair_en_o` bits and `fb_en_o` are 1, and `sda_oe_o` is 0.
- R2: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read) by driving SDA low in the ninth clock. For any other address it gives no acknowledge, ignores the bus until the next START, and changes no register.
- R3: In a write, every byte after the address is acknowledged. The first two are discarded, and data byte k of the transfer is stored in bank byte k for k = 0..8.
- R4: An enable bit of 1 turns its output on. Byte 7 bit 0 drives pair 0, bit 2 drives pair 1, bit 5 drives pair 2 and bit 6 drives pair 3. Byte 6 bit 1 drives pair 4, bit 3 drives pair 5 and bit 4 drives the feedback enable. The other bits drive no output.
- R5: A read returns first the count byte 0x09 and then bank bytes 0, 1, 2 and so on, most significant bit first. Bit 7 of byte 6 always reads the current mode-select level, and writes to that bit have no effect.
- R6: The bank resets to byte 6 = 0x1F (bits 6..0), byte 7 = 0xFF and every other byte 0x00.
- R7: Write data beyond bank byte 8 is acknowledged and discarded. Reads beyond bank byte 8 return 0xFF.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and drives it no more until the next START.
- R9: A repeated START in the middle of a write restarts the sequence, so the next data byte goes to bank byte 0 again.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the bus (asynchronous) |
| mode_sel_i | input | 1 | DDR/SDR mode-select pin level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| pair_en_o | output | 6 | Enable per output pair, bit n for pair n |
| fb_en_o | output | 1 | Feedback output enable |

## Verification
A wrong bit or byte counter shows up as an acknowledge in the wrong clock, or as a read byte that is shifted by one or more bit positions. The master sees either one within the same byte. A wrong write pointer stores data in the wrong bank byte. The bench reads the bank back after each write and compares every byte against its model, and it also checks the enable outputs within a few system cycles of the STOP. A state that fails to return to idle after a master NACK or a foreign address appears as SDA driven low during the clocks that follow.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WRITE, ST_READ} seq_st_e;
  localparam int unsigned NUM_PAIRS = 6;
endpackage

// File: rtl/fes_sync.sv
module fes_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/fes_bank.sv
module fes_bank
  import fes_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 9,
  parameter int unsigned POS_W     = 5,
  parameter int unsigned OUT_HI    = 6,
  parameter int unsigned OUT_LO    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic                 wr_en_i,
  input  logic [POS_W-1:0]     wr_pos_i,
  input  logic [7:0]           wr_data_i,
  input  logic [POS_W-1:0]     rd_pos_i,
  output logic [7:0]           rd_byte_o,
  output logic [NUM_PAIRS-1:0] pair_en_o,
  output logic                 fb_en_o
);
  localparam logic [POS_W-1:0] WR_SKIP = POS_W'(2);
  localparam logic [7:0]       CNT_VAL = 8'(NUM_BYTES);

  function automatic logic [7:0] rst_byte(int unsigned i);
    if (i == OUT_HI) return 8'h1F;
    if (i == OUT_LO) return 8'hFF;
    return 8'h00;
  endfunction

  logic [7:0]       mem_q [NUM_BYTES];
  logic [POS_W-1:0] wr_idx, rd_idx;

  assign wr_idx = wr_pos_i - WR_SKIP;
  assign rd_idx = rd_pos_i - POS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < NUM_BYTES; i++) mem_q[i] <= rst_byte(i);
    end else if (wr_en_i && wr_pos_i >= WR_SKIP) begin
      for (int unsigned i = 0; i < NUM_BYTES; i++)
        if (wr_idx == POS_W'(i)) mem_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_byte_o = 8'hFF;
    if (rd_pos_i == '0) rd_byte_o = CNT_VAL;
    else begin
      for (int unsigned i = 0; i < NUM_BYTES; i++)
        if (rd_idx == POS_W'(i)) rd_byte_o = mem_q[i];
      if (rd_idx == POS_W'(OUT_HI)) rd_byte_o[7] = mode_i;
    end
  end

  assign pair_en_o = {mem_q[OUT_HI][3], mem_q[OUT_HI][1], mem_q[OUT_LO][6],
                      mem_q[OUT_LO][5], mem_q[OUT_LO][2], mem_q[OUT_LO][0]};
  assign fb_en_o   = mem_q[OUT_HI][4];

  p_lo_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_pos_i == POS_W'(OUT_LO + 2)) |=>
      pair_en_o[3:0] == {$past(wr_data_i[6]), $past(wr_data_i[5]),
                         $past(wr_data_i[2]), $past(wr_data_i[0])});
  p_hi_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_pos_i == POS_W'(OUT_HI + 2)) |=>
      fb_en_o == $past(wr_data_i[4]) && pair_en_o[5:4] == {$past(wr_data_i[3]), $past(wr_data_i[1])});
endmodule

// File: rtl/fes_seq.sv
module fes_seq
  import fes_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned POS_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [7:0]       rd_byte_i,
  output logic [POS_W-1:0] rd_pos_o,
  output logic             wr_en_o,
  output logic [POS_W-1:0] wr_pos_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);
  seq_st_e          st_q;
  logic [3:0]       bit_q;
  logic             ack_q, scl_p, sda_p;
  logic [7:0]       sh_q;
  logic [POS_W-1:0] pos_q, pos_inc;
  logic             start, stop, scl_rise, scl_fall, in_bits;

  assign start    = scl_i & scl_p & sda_p & ~sda_i;
  assign stop     = scl_i & scl_p & ~sda_p & sda_i;
  assign scl_rise = scl_i & ~scl_p;
  assign scl_fall = ~scl_i & scl_p;
  assign in_bits  = ~ack_q & (bit_q < 4'd8);
  assign pos_inc  = (&pos_q) ? pos_q : pos_q + POS_W'(1);
  assign rd_pos_o = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; bit_q <= '0; ack_q <= 1'b0; sh_q <= '0; pos_q <= '0;
      scl_p <= 1'b1; sda_p <= 1'b1; sda_oe_o <= 1'b0;
      wr_en_o <= 1'b0; wr_pos_o <= '0; wr_data_o <= '0;
    end else begin
      scl_p   <= scl_i;
      sda_p   <= sda_i;
      wr_en_o <= 1'b0;
      if (start) begin
        st_q <= ST_ADDR; bit_q <= '0; ack_q <= 1'b0; sda_oe_o <= 1'b0; pos_q <= '0;
      end else if (stop) begin
        st_q <= ST_IDLE; ack_q <= 1'b0; sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WRITE: begin
            if (scl_rise && in_bits) begin
              sh_q  <= {sh_q[6:0], sda_i};
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall && !ack_q && bit_q == 4'd8) begin
              ack_q <= 1'b1;
              if (st_q == ST_WRITE) begin
                sda_oe_o <= 1'b1;
                wr_en_o <= 1'b1; wr_pos_o <= pos_q; wr_data_o <= sh_q;
              end else if (sh_q[7:1] == DEV_ADDR) sda_oe_o <= 1'b1;
              else st_q <= ST_IDLE;  // foreign address: silent until START
            end else if (scl_fall && ack_q) begin
              ack_q <= 1'b0;
              bit_q <= '0;
              if (st_q == ST_ADDR && sh_q[0]) begin
                st_q     <= ST_READ;
                sh_q     <= rd_byte_i;
                sda_oe_o <= ~rd_byte_i[7];
                pos_q    <= pos_inc;
              end else begin
                sda_oe_o <= 1'b0;
                if (st_q == ST_WRITE) pos_q <= pos_inc;
                st_q <= ST_WRITE;
              end
            end
          end
          ST_READ: begin
            if (scl_rise && in_bits) bit_q <= bit_q + 4'd1;
            else if (scl_fall && in_bits && bit_q != 4'd0) begin
              sh_q     <= {sh_q[6:0], 1'b0};
              sda_oe_o <= ~sh_q[6];
            end else if (scl_fall && !ack_q && bit_q == 4'd8) begin
              sda_oe_o <= 1'b0;
              ack_q    <= 1'b1;
            end else if (scl_rise && ack_q && sda_i) begin
              st_q  <= ST_IDLE;   // master NACK ends the read
              ack_q <= 1'b0;
            end else if (scl_fall && ack_q) begin
              ack_q    <= 1'b0;
              bit_q    <= '0;
              sh_q     <= rd_byte_i;
              sda_oe_o <= ~rd_byte_i[7];
              pos_q    <= pos_inc;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  p_nack_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READ && ack_q && scl_rise && sda_i && !start && !stop) |=>
      (st_q == ST_IDLE && !sda_oe_o));
  p_foreign_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && scl_fall && !ack_q && bit_q == 4'd8 && sh_q[7:1] != DEV_ADDR) |=>
      (st_q == ST_IDLE && !sda_oe_o));
  p_scl_high_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_p && scl_i && !start && !stop) |=> $stable(sda_oe_o));
endmodule

// File: rtl/fanout_enable_slave.sv
module fanout_enable_slave
  import fes_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  parameter int unsigned NUM_BYTES = 9,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 mode_sel_i,
  output logic                 sda_oe_o,
  output logic [NUM_PAIRS-1:0] pair_en_o,
  output logic                 fb_en_o
);
  localparam int unsigned POS_W = $clog2(NUM_BYTES + 3) + 1;

  logic [2:0]       sync_v;
  logic [POS_W-1:0] rd_pos, wr_pos;
  logic [7:0]       rd_byte, wr_data;
  logic             wr_en;

  fes_sync #(.W(3), .STAGES(SYNC_LEN), .RST_VAL(3'b011)) i_sync (
    .clk_i, .rst_ni,
    .async_i({mode_sel_i, sda_i, scl_i}),
    .sync_o (sync_v)
  );

  fes_seq #(.DEV_ADDR(DEV_ADDR), .POS_W(POS_W)) i_seq (
    .clk_i, .rst_ni,
    .scl_i    (sync_v[0]),
    .sda_i    (sync_v[1]),
    .rd_byte_i(rd_byte),
    .rd_pos_o (rd_pos),
    .wr_en_o  (wr_en),
    .wr_pos_o (wr_pos),
    .wr_data_o(wr_data),
    .sda_oe_o (sda_oe_o)
  );

  fes_bank #(.NUM_BYTES(NUM_BYTES), .POS_W(POS_W)) i_bank (
    .clk_i, .rst_ni,
    .mode_i   (sync_v[2]),
    .wr_en_i  (wr_en),
    .wr_pos_i (wr_pos),
    .wr_data_i(wr_data),
    .rd_pos_i (rd_pos),
    .rd_byte_o(rd_byte),
    .pair_en_o(pair_en_o),
    .fb_en_o  (fb_en_o)
  );
endmodule

// File: tb/test_fanout_enable_slave.sv
module test_fanout_enable_slave;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, mode = 1'b0;
  logic       sda_oe, fb_en;
  logic [5:0] pair_en;
  wire        sda_bus = sda_m & ~sda_oe;

  fanout_enable_slave i_fanout_enable_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .mode_sel_i(mode), .sda_oe_o(sda_oe), .pair_en_o(pair_en), .fb_en_o(fb_en)
  );

  int checks = 0, errors = 0, r10_viol = 0;
  logic [7:0] exp_mem [9];
  logic done = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wq(int n = 1); repeat (n * Q) @(negedge clk); endtask

  function automatic logic [7:0] exp_read(int k);
    if (k > 8) return 8'hFF;
    if (k == 6) return {mode, exp_mem[6][6:0]};
    return exp_mem[k];
  endfunction
  function automatic logic [5:0] exp_pairs();
    return {exp_mem[6][3], exp_mem[6][1], exp_mem[7][6], exp_mem[7][5], exp_mem[7][2], exp_mem[7][0]};
  endfunction

  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && sda_oe !== prev_oe) r10_viol++;
    prev_scl = scl_m; prev_oe = sda_oe;
  end

  task automatic start_c(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq(); endtask
  task automatic stop_c();  sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); endtask

  task automatic send(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_bus;
    scl_m = 1'b0; wq();
  endtask

  task automatic recv(logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; scl_m = 1'b0;
    end
    wq(); sda_m = ~m_ack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic wr_txn(int n);
    logic a; logic [7:0] d;
    start_c();
    send(8'hD2, a); check("R2 write address ack", a, 1);
    send(8'($urandom), a); check("R3 command byte ack", a, 1);
    send(8'($urandom), a); check("R3 count byte ack", a, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send(d, a);
      if (k < 9) begin check("R3 data ack", a, 1); exp_mem[k] = d; end
      else check("R7 overflow ack", a, 1);
    end
    stop_c(); wq();
    check("R4 pair enables", pair_en, exp_pairs());
    check("R4 feedback enable", fb_en, exp_mem[6][4]);
  endtask

  task automatic rd_txn(int n);
    logic a; logic [7:0] b;
    start_c();
    send(8'hD3, a); check("R2 read address ack", a, 1);
    recv(n > 0, b); check("R5 count byte", b, 8'h09);
    for (int k = 0; k < n; k++) begin
      recv(k < n - 1, b);
      check(k > 8 ? "R7 read past end" : "R5 read data", b, exp_read(k));
    end
    check("R8 released after nack", sda_oe, 0);
    stop_c(); wq();
  endtask

  initial begin
    logic a; logic [7:0] b, adr;
    void'($urandom(32'hC10C));
    for (int i = 0; i < 9; i++) exp_mem[i] = (i == 6) ? 8'h1F : (i == 7) ? 8'hFF : 8'h00;
    repeat (5) @(negedge clk);
    check("R1 reset pairs", pair_en, 6'h3F);
    check("R1 reset fb", fb_en, 1);
    check("R1 reset sda", sda_oe, 0);
    rst_n = 1'b1; wq(2);
    rd_txn(9);                         // R6 reset contents
    wr_txn(9);
    rd_txn(9);
    wr_txn(11);                        // R7 overflow
    rd_txn(11);
    // R2: foreign address, nothing acked, nothing changed
    do adr = 8'($urandom); while (adr[7:1] == 7'h69);
    start_c(); send(adr, a); check("R2 foreign address nack", a, 0);
    send(8'h00, a); check("R2 ignored after foreign address", a, 0);
    stop_c(); wq();
    check("R2 pairs unchanged", pair_en, exp_pairs());
    rd_txn(9);
    // R9: repeated start rewinds to byte 0
    start_c(); send(8'hD2, a); send(8'h00, a); send(8'h09, a);
    send(8'hA5, a); send(8'h3C, a);
    exp_mem[0] = 8'hA5; exp_mem[1] = 8'h3C;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    send(8'hD2, a); check("R9 address after repeated start", a, 1);
    send(8'h00, a); send(8'h09, a); send(8'h5A, a);
    exp_mem[0] = 8'h5A;
    stop_c(); wq();
    rd_txn(2);
    // R8: nack mid read, then no more drive
    start_c(); send(8'hD3, a); recv(1'b1, b); recv(1'b0, b);
    check("R8 byte before nack", b, exp_read(0));
    for (int i = 0; i < 9; i++) begin
      wq(); scl_m = 1'b1; wq();
      if (sda_bus !== 1'b1) begin check("R8 no drive after nack", sda_bus, 1); end
      scl_m = 1'b0; wq();
    end
    check("R8 idle after nack", sda_oe, 0);
    stop_c(); wq();
    // R5: mode pin visible, write to bit 7 ignored
    mode = 1'b1; wq(2);
    start_c(); send(8'hD2, a); send(8'h00, a); send(8'h09, a);
    for (int k = 0; k < 7; k++) send(k == 6 ? 8'h1B : exp_mem[k], a);
    exp_mem[6] = 8'h1B;
    stop_c(); wq();
    rd_txn(8);
    mode = 1'b0; wq(2);
    rd_txn(7);
    for (int t = 0; t < 6; t++) begin
      mode = 1'($urandom);
      wq(2);
      wr_txn(1 + int'($urandom % 11));
      rd_txn(int'($urandom % 12));
    end
    check("R10 sda drive changed with SCL high", r10_viol, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule